// File: doc/BRIEF.md
# Byte-Serial Wide Subtract and Compare Unit

This block is an 8-bit arithmetic slice that subtracts or compares operands wider than one byte by working through them one byte per clock. Each step feeds its borrow and its zero status into the next one, so once the most significant byte has been handled, the status flags describe the whole wide result rather than only the last byte.

Byte operations can be issued directly on the operand ports. Four opcodes are supported: plain subtract, subtract with borrow, compare, and compare with borrow. There is also a small built-in sequencer. It takes two full-width operands and walks them from the lowest byte to the highest, using a plain compare first and a compare-with-borrow for every later byte. When it finishes, the flags tell whether the operands were equal, whether the first was unsigned-lower, and whether it was signed-less.

Top module: `chained_cmp_alu`

## Requirements
- R1: A byte operation presented with `op_valid` high is fully applied at that same clock edge. The result register and the flags show its outcome in the next cycle.
- R2: Opcode 2'b00 (subtract) and 2'b01 (subtract with borrow) load `res` with A−B (−C for 2'b01), modulo 256. They raise `res_we` for exactly one cycle.
- R3: Opcode 2'b10 (compare) and 2'b11 (compare with borrow) update the flags only. `res_we` stays low and `res` keeps its previous value.
- R4: Opcodes with bit 0 set subtract the stored C as a borrow. For all opcodes, C becomes 1 exactly when the unsigned subtraction borrows out of bit 7.
- R5: Opcodes 2'b01 and 2'b11 set Z only when the byte result is zero and Z was already 1. A nonzero byte result clears Z.
- R6: Opcodes 2'b00 and 2'b10 set Z from this byte's result alone, without regard to the previous Z.
- R7: N is bit 7 of the byte result. V is two's-complement overflow of the subtraction. S equals N XOR V.
- R8: In a cycle with no operation, all five flags keep their values.
- R9: A `wide_start` pulse while idle runs exactly 4 byte compares on 4 consecutive edges, low byte first. `wide_busy` is high during those 4 cycles, and `wide_done` pulses for one cycle after the last edge.
- R10: After a wide compare, Z=1 exactly when the operands are equal, C=1 exactly when A<B unsigned, and S=1 exactly when A<B signed.
- R11: While `wide_busy` is high, `op_valid` and its operands are ignored.
- R12: Synchronous reset clears `res`, `res_we`, all flags, `wide_busy` and `wide_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Issue one byte operation this cycle |
| op_code | input | 2 | 00 sub, 01 sub-borrow, 10 cmp, 11 cmp-borrow |
| opa | input | 8 | First operand byte |
| opb | input | 8 | Second operand byte |
| wide_start | input | 1 | Begin a wide compare |
| wide_a | input | 32 | Wide first operand |
| wide_b | input | 32 | Wide second operand |
| res | output | 8 | Registered byte result |
| res_we | output | 1 | Result write-enable pulse |
| flag_c | output | 1 | Borrow flag |
| flag_z | output | 1 | Zero flag |
| flag_n | output | 1 | Negative flag |
| flag_v | output | 1 | Overflow flag |
| flag_s | output | 1 | Sign flag (N xor V) |
| wide_busy | output | 1 | Sequencer is walking bytes |
| wide_done | output | 1 | Wide compare finished |

## Verification
The assertions assume that `wide_start` is sampled only while the sequencer is idle. They also assume that `op_code` carries a meaningful value whenever `op_valid` is high. The stimulus raises `wide_start` only after `wide_done` has been seen, and it drives a defined opcode with every valid pulse. One scenario deliberately raises `op_valid` during a busy walk, to exercise the ignore path.

// File: rtl/cmp_alu_pkg.sv
package cmp_alu_pkg;
  typedef enum logic [1:0] {
    OP_SUB = 2'b00,
    OP_SBC = 2'b01,
    OP_CP  = 2'b10,
    OP_CPC = 2'b11
  } alu_op_e;

  typedef struct packed {
    logic c;
    logic z;
    logic n;
    logic v;
    logic s;
  } flags_t;
endpackage

// File: rtl/sub_byte_core.sv
module sub_byte_core
  import cmp_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  alu_op_e           op,
  input  flags_t            prev,
  output logic [DATA_W-1:0] r,
  output flags_t            nxt
);
  logic              chain;
  logic              cin;
  logic [DATA_W:0]   diff;
  logic              is_zero;

  always_comb begin
    chain   = op[0];
    cin     = chain & prev.c;
    diff    = {1'b0, a} - {1'b0, b} - {{DATA_W{1'b0}}, cin};
    r       = diff[DATA_W-1:0];
    is_zero = (r == '0);
    nxt.c   = diff[DATA_W];
    nxt.z   = chain ? (is_zero & prev.z) : is_zero;
    nxt.n   = r[DATA_W-1];
    nxt.v   = (a[DATA_W-1] ^ b[DATA_W-1]) & (a[DATA_W-1] ^ r[DATA_W-1]);
    nxt.s   = nxt.n ^ nxt.v;
  end
endmodule

// File: rtl/status_reg.sv
module status_reg
  import cmp_alu_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   load,
  input  flags_t nxt,
  output flags_t cur
);
  always_ff @(posedge clk) begin
    if (rst)       cur <= '0;
    else if (load) cur <= nxt;
  end

  assert_flags_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(cur));
endmodule

// File: rtl/wide_walk_seq.sv
module wide_walk_seq
  import cmp_alu_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int NBYTES = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start,
  input  logic [DATA_W*NBYTES-1:0] a_in,
  input  logic [DATA_W*NBYTES-1:0] b_in,
  output logic                     busy,
  output logic                     done,
  output alu_op_e                  step_op,
  output logic [DATA_W-1:0]        step_a,
  output logic [DATA_W-1:0]        step_b
);
  localparam int WIDE_W = DATA_W * NBYTES;
  localparam int IDX_W  = $clog2(NBYTES + 1);

  logic [WIDE_W-1:0] a_sh, b_sh;
  logic [IDX_W-1:0]  idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      done <= 1'b0;
      idx  <= '0;
      a_sh <= '0;
      b_sh <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy <= 1'b1;
          idx  <= '0;
          a_sh <= a_in;
          b_sh <= b_in;
        end
      end else begin
        a_sh <= a_sh >> DATA_W;
        b_sh <= b_sh >> DATA_W;
        idx  <= idx + 1'b1;
        if (idx == IDX_W'(NBYTES - 1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  assign step_op = (idx == '0) ? OP_CP : OP_CPC;
  assign step_a  = a_sh[DATA_W-1:0];
  assign step_b  = b_sh[DATA_W-1:0];

  // independent count of busy cycles, used only by the check below
  logic [IDX_W:0] busy_cnt;
  always_ff @(posedge clk) begin
    if (rst)       busy_cnt <= '0;
    else if (busy) busy_cnt <= busy_cnt + 1'b1;
    else           busy_cnt <= '0;
  end

  assert_walk_length_R9: assert property (@(posedge clk) disable iff (rst)
    done |-> busy_cnt == (IDX_W+1)'(NBYTES));
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

// File: rtl/chained_cmp_alu.sv
module chained_cmp_alu
  import cmp_alu_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int NBYTES = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     op_valid,
  input  logic [1:0]               op_code,
  input  logic [DATA_W-1:0]        opa,
  input  logic [DATA_W-1:0]        opb,
  input  logic                     wide_start,
  input  logic [DATA_W*NBYTES-1:0] wide_a,
  input  logic [DATA_W*NBYTES-1:0] wide_b,
  output logic [DATA_W-1:0]        res,
  output logic                     res_we,
  output logic                     flag_c,
  output logic                     flag_z,
  output logic                     flag_n,
  output logic                     flag_v,
  output logic                     flag_s,
  output logic                     wide_busy,
  output logic                     wide_done
);
  alu_op_e           seq_op, sel_op;
  logic [DATA_W-1:0] seq_a, seq_b, sel_a, sel_b, core_r;
  logic              issue;
  flags_t            cur, nxt;

  wide_walk_seq #(.DATA_W(DATA_W), .NBYTES(NBYTES)) u_seq (
    .clk(clk), .rst(rst), .start(wide_start),
    .a_in(wide_a), .b_in(wide_b),
    .busy(wide_busy), .done(wide_done),
    .step_op(seq_op), .step_a(seq_a), .step_b(seq_b)
  );

  always_comb begin
    issue  = wide_busy | op_valid;
    sel_op = wide_busy ? seq_op : alu_op_e'(op_code);
    sel_a  = wide_busy ? seq_a  : opa;
    sel_b  = wide_busy ? seq_b  : opb;
  end

  sub_byte_core #(.DATA_W(DATA_W)) u_core (
    .a(sel_a), .b(sel_b), .op(sel_op), .prev(cur),
    .r(core_r), .nxt(nxt)
  );

  status_reg u_flags (
    .clk(clk), .rst(rst), .load(issue), .nxt(nxt), .cur(cur)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res    <= '0;
      res_we <= 1'b0;
    end else begin
      res_we <= issue & ~sel_op[1];
      if (issue & ~sel_op[1]) res <= core_r;
    end
  end

  assign flag_c = cur.c;
  assign flag_z = cur.z;
  assign flag_n = cur.n;
  assign flag_v = cur.v;
  assign flag_s = cur.s;

  assert_we_only_sub_R3: assert property (@(posedge clk) disable iff (rst)
    issue && sel_op[1] |=> !res_we && $stable(res));
  assert_z_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    issue && sel_op[0] && !flag_z |=> !flag_z);
  assert_borrow_R4: assert property (@(posedge clk) disable iff (rst)
    issue && !sel_op[0] && (sel_a < sel_b) |=> flag_c);
  assert_sign_rule_R7: assert property (@(posedge clk) disable iff (rst)
    flag_s == (flag_n ^ flag_v));
endmodule

// File: tb/chained_cmp_alu_bench.sv
module chained_cmp_alu_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        op_valid;
  logic [1:0]  op_code;
  logic [7:0]  opa, opb;
  logic        wide_start;
  logic [31:0] wide_a, wide_b;
  logic [7:0]  res;
  logic        res_we, flag_c, flag_z, flag_n, flag_v, flag_s;
  logic        wide_busy, wide_done;

  int total = 0;
  int bad   = 0;
  logic mc, mz;

  always #5 clk = ~clk;

  chained_cmp_alu u_chained_cmp_alu (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
    .opa(opa), .opb(opb), .wide_start(wide_start),
    .wide_a(wide_a), .wide_b(wide_b), .res(res), .res_we(res_we),
    .flag_c(flag_c), .flag_z(flag_z), .flag_n(flag_n), .flag_v(flag_v),
    .flag_s(flag_s), .wide_busy(wide_busy), .wide_done(wide_done)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  // byte op with independent reference; checks result, we and all flags
  task automatic byte_op(input logic [1:0] code, input logic [7:0] a, input logic [7:0] b);
    int d, sd, cin;
    logic [7:0] r, old_res;
    logic ec, ez, en, ev;
    cin = code[0] ? int'(mc) : 0;
    d   = int'(a) - int'(b) - cin;
    sd  = int'($signed(a)) - int'($signed(b)) - cin;
    r   = d[7:0];
    ec  = d < 0;
    ez  = code[0] ? ((r == 0) && mz) : (r == 0);
    en  = r[7];
    ev  = (sd < -128) || (sd > 127);
    old_res = res;
    @(negedge clk);
    op_valid = 1'b1; op_code = code; opa = a; opb = b;
    @(negedge clk);
    op_valid = 1'b0;
    if (code[1]) begin
      chk("R3 cmp no write-enable", res_we, 0);
      chk("R3 cmp keeps res", res, old_res);
    end else begin
      chk("R2 result value", res, r);
      chk("R2 write-enable", res_we, 1);
    end
    chk("R4 borrow flag", flag_c, ec);
    chk(code[0] ? "R5 chained zero" : "R6 plain zero", flag_z, ez);
    chk("R7 negative", flag_n, en);
    chk("R7 overflow", flag_v, ev);
    chk("R7 sign", flag_s, en ^ ev);
    mc = ec; mz = ez;
  endtask

  task automatic wide_cmp(input logic [31:0] a, input logic [31:0] b, input bit poke);
    @(negedge clk);
    wide_start = 1'b1; wide_a = a; wide_b = b;
    @(negedge clk);
    wide_start = 1'b0;
    chk("R9 busy after start", wide_busy, 1);
    if (poke) begin
      op_valid = 1'b1; op_code = 2'b00; opa = 8'h00; opb = 8'h01;
    end
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R9 busy during walk", wide_busy, 1);
      if (poke) chk("R11 ignored op no write", res_we, 0);
    end
    @(negedge clk);
    op_valid = 1'b0;
    chk("R9 done pulse", wide_done, 1);
    chk("R9 idle after walk", wide_busy, 0);
    chk("R10 equal", flag_z, a == b);
    chk("R10 unsigned lower", flag_c, a < b);
    chk("R10 signed less", flag_s, $signed(a) < $signed(b));
    @(negedge clk);
    chk("R9 done one cycle", wide_done, 0);
    mc = flag_c; mz = flag_z;
  endtask

  task automatic t_reset();
    chk("R12 res", res, 0);
    chk("R12 we", res_we, 0);
    chk("R12 flags", {flag_c, flag_z, flag_n, flag_v, flag_s}, 0);
    chk("R12 busy/done", {wide_busy, wide_done}, 0);
    mc = 0; mz = 0;
  endtask

  task automatic t_sixteen_bit();
    byte_op(2'b00, 8'h04, 8'h01);   // E104 - E101 low byte
    byte_op(2'b01, 8'hE1, 8'hE1);   // high byte zero but Z must stay 0
    chk("R5 E104-E101 not zero", flag_z, 0);
    byte_op(2'b00, 8'h00, 8'h01);   // borrow out
    byte_op(2'b01, 8'h10, 8'h0F);   // 10-0F-1 = 0, Z was 0
    byte_op(2'b10, 8'h55, 8'h55);   // plain compare sets Z
    byte_op(2'b11, 8'h80, 8'h80);   // chained zero keeps Z
    byte_op(2'b00, 8'h80, 8'h01);   // overflow
    byte_op(2'b10, 8'h7F, 8'hFF);   // overflow in compare
  endtask

  task automatic t_hold();
    logic [4:0] f;
    f = {flag_c, flag_z, flag_n, flag_v, flag_s};
    repeat (3) @(negedge clk);
    chk("R8 flags hold idle", {flag_c, flag_z, flag_n, flag_v, flag_s}, f);
    chk("R1 we low when idle", res_we, 0);
  endtask

  task automatic t_wide_directed();
    wide_cmp(32'h1234_5678, 32'h1234_5678, 0);
    wide_cmp(32'h1234_0000, 32'h1234_0001, 0);
    wide_cmp(32'h8000_0000, 32'h0000_0001, 0);
    wide_cmp(32'h0000_0100, 32'h0000_0001, 0);
    wide_cmp(32'h5500_0000, 32'h5400_0000, 1);
  endtask

  task automatic t_random();
    for (int i = 0; i < 20; i++) wide_cmp($urandom, $urandom, 0);
    for (int i = 0; i < 10; i++) begin
      byte_op(2'b00, 8'($urandom), 8'($urandom));
      byte_op(2'b01, 8'($urandom), 8'($urandom));
    end
  endtask

  initial begin
    op_valid = 0; op_code = 0; opa = 0; opb = 0;
    wide_start = 0; wide_a = 0; wide_b = 0;
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_sixteen_bit();
    t_hold();
    t_wide_directed();
    t_random();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule